// File: doc/BRIEF.md
# Edge-Triggered Peripheral Reset Controller

This block is a bank of word-addressed reset-level registers for a low-power peripheral domain. Each register stores the reset level of one peripheral, of a group of peripherals, or of a pair of processor cores. Software writes a level, and the block turns every change of a controlling bit into an action toward the attached target. A write that leaves a bit unchanged produces no action.

For a processor core, a rising bit requests power-off and a falling bit requests power-on with restart. These two requests are separate one-cycle strobes. For an ordinary peripheral, a change in either direction issues a one-cycle cold-reset pulse. A single DMA bit drives the resets of all DMA channels at once. Some registers are storage only and drive no action: the timer group, the debug domain and the full-power domain. The power sequencing and the targets themselves sit outside the block.

Top module: `prc_top`

## Requirements
- R1: After the block leaves reset, the registers hold these values: core register 0x17, DMA register 0x1, timer register 0xF, debug register 0x33, full-power-domain register 0x3, and every peripheral register 0x1. No action output is active in the cycles after reset.
- R2: The register map uses word addresses. Address 0 is the core register, 1 is DMA, 2 is timer, 3 is debug and 4 is full-power domain. Addresses 5 to 5+N_PERIPH-1 hold peripheral 0 upward. rdata shows the register at `addr` combinationally.
- R3: A write with `wr_en` high stores `wdata` AND the register's writable mask, and a read then returns that stored value. The masks are 0x17 (core; bit 3 reserved), 0x1 (DMA and peripherals), 0xF (timer), 0x33 (debug) and 0x3 (full-power domain). Reserved bits read as zero.
- R4: A write to an address at or above 5+N_PERIPH changes nothing and fires no action, and a read there returns zero.
- R5: Writing a controlling bit with the value it already holds fires no action.
- R6: In the core register, bit 0 controls core 0 and bit 1 controls core 1. A 0-to-1 change of a core bit raises `core_off` for that core.
- R7: A 1-to-0 change of a core bit raises `core_on` (power on with restart) for that core. `core_on` and `core_off` are never both high for one core.
- R8: A change of bit 0 of a peripheral register in either direction raises that peripheral's `per_rst` bit.
- R9: A change of bit 0 of the DMA register raises every `dma_rst` bit in the same cycle.
- R10: Bits other than the controlling bits fire no action. This covers core bits 2 and 4 and all of the timer, debug and full-power-domain registers.
- R11: Each action is a registered strobe. It is high for exactly the one cycle that follows the clock edge that accepted the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; loads reset values |
| wr_en | input | 1 | Write strobe for the register at addr |
| addr | input | ADDR_W | Word address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the register at addr |
| core_off | output | 2 | Per-core power-off strobe |
| core_on | output | 2 | Per-core power-on-and-restart strobe |
| dma_rst | output | N_DMA_CH | Cold-reset pulse to each DMA channel |
| per_rst | output | N_PERIPH | Cold-reset pulse to each peripheral |

## Verification
The bench builds the block with N_DMA_CH=3, N_PERIPH=4 and ADDR_W=4. This leaves addresses 9 to 15 unmapped, so random addresses often land outside the map, and writes that must be ignored are common. With three DMA channels, a broken fan-out shows up as a partial pattern, not as all or nothing. With four peripheral registers, an index error in the edge generate loop pulses the wrong output. Random data makes repeated values and changes of reserved bits happen often, and the directed steps force both edge directions on each core.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned NCORE  = 2;
  localparam int unsigned IX_CORE = 0;
  localparam int unsigned IX_DMA  = 1;
  localparam int unsigned IX_TMR  = 2;
  localparam int unsigned IX_DBG  = 3;
  localparam int unsigned IX_FPD  = 4;
  localparam int unsigned IX_PER0 = 5;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  // Value loaded when the block leaves reset
  function automatic logic [DW-1:0] init_val(int unsigned ix);
    case (ix)
      IX_CORE: return 32'h0000_0017;
      IX_TMR:  return 32'h0000_000F;
      IX_DBG:  return 32'h0000_0033;
      IX_FPD:  return 32'h0000_0003;
      default: return 32'h0000_0001;
    endcase
  endfunction

  // Bits that hold state; every other bit is reserved
  function automatic logic [DW-1:0] keep_mask(int unsigned ix);
    case (ix)
      IX_CORE: return 32'h0000_0017;
      IX_TMR:  return 32'h0000_000F;
      IX_DBG:  return 32'h0000_0033;
      IX_FPD:  return 32'h0000_0003;
      default: return 32'h0000_0001;
    endcase
  endfunction

  function automatic logic [DW-1:0] apply_write(int unsigned ix, logic [DW-1:0] wd);
    return wd & keep_mask(ix);
  endfunction

  function automatic edge_t bit_edge(logic was, logic nxt);
    edge_t e;
    e.rise = !was && nxt;
    e.fall = was && !nxt;
    return e;
  endfunction
endpackage

// File: rtl/prc_regbank.sv
module prc_regbank
  import prc_pkg::*;
#(
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rdata,
  output logic [NCORE-1:0]    core_cur,
  output logic [NCORE-1:0]    core_nxt,
  output logic                dma_cur,
  output logic                dma_nxt,
  output logic [N_PERIPH-1:0] per_cur,
  output logic [N_PERIPH-1:0] per_nxt
);
  localparam int unsigned NREG = IX_PER0 + N_PERIPH;

  logic [NREG-1:0][DW-1:0] q;
  logic [NREG-1:0][DW-1:0] nxt;
  logic [NREG-1:0]         hit;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [DW-1:0] MSK = keep_mask(g);
    assign hit[g] = wr_en && (addr == ADDR_W'(g));
    assign nxt[g] = hit[g] ? apply_write(g, wdata) : q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= init_val(g);
      else        q[g] <= nxt[g];
    end

    // R3
    resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q[g] & ~MSK) == '0);
    // R4
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[g] |=> $stable(q[g]));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rdata = q[i];
    end
  end

  assign core_cur = q[IX_CORE][NCORE-1:0];
  assign core_nxt = nxt[IX_CORE][NCORE-1:0];
  assign dma_cur  = q[IX_DMA][0];
  assign dma_nxt  = nxt[IX_DMA][0];

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
    assign per_cur[p] = q[IX_PER0+p][0];
    assign per_nxt[p] = nxt[IX_PER0+p][0];
  end
endmodule

// File: rtl/prc_edge_act.sv
module prc_edge_act
  import prc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic was,
  input  logic nxt,
  output logic rise_p,
  output logic fall_p
);
  edge_t e;
  assign e = bit_edge(was, nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_p <= 1'b0;
      fall_p <= 1'b0;
    end else begin
      rise_p <= e.rise;
      fall_p <= e.fall;
    end
  end

  // R7
  rise_fall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_p && fall_p));
endmodule

// File: rtl/prc_top.sv
module prc_top
  import prc_pkg::*;
#(
  parameter int unsigned N_DMA_CH = 8,
  parameter int unsigned N_PERIPH = 8,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  output logic [1:0]          core_off,
  output logic [1:0]          core_on,
  output logic [N_DMA_CH-1:0] dma_rst,
  output logic [N_PERIPH-1:0] per_rst
);
  logic [NCORE-1:0]    core_cur, core_nxt;
  logic                dma_cur, dma_nxt;
  logic [N_PERIPH-1:0] per_cur, per_nxt;
  logic                dma_rise, dma_fall;
  logic [N_PERIPH-1:0] per_rise, per_fall;

  prc_regbank #(.N_PERIPH(N_PERIPH), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_cur(core_cur), .core_nxt(core_nxt),
    .dma_cur(dma_cur), .dma_nxt(dma_nxt),
    .per_cur(per_cur), .per_nxt(per_nxt)
  );

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    prc_edge_act u_edge (
      .clk(clk), .rst_n(rst_n), .was(core_cur[c]), .nxt(core_nxt[c]),
      .rise_p(core_off[c]), .fall_p(core_on[c])
    );
    // R6
    core_off_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_off[c] |-> (core_cur[c] && !$past(core_cur[c])));
    // R7
    core_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_on[c] |-> (!core_cur[c] && $past(core_cur[c])));
  end

  prc_edge_act u_dma_edge (
    .clk(clk), .rst_n(rst_n), .was(dma_cur), .nxt(dma_nxt),
    .rise_p(dma_rise), .fall_p(dma_fall)
  );
  assign dma_rst = {N_DMA_CH{dma_rise | dma_fall}};

  // R9
  dma_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(dma_rst) == 0) || ($countones(dma_rst) == N_DMA_CH));

  for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
    prc_edge_act u_edge (
      .clk(clk), .rst_n(rst_n), .was(per_cur[p]), .nxt(per_nxt[p]),
      .rise_p(per_rise[p]), .fall_p(per_fall[p])
    );
    assign per_rst[p] = per_rise[p] | per_fall[p];
    // R5
    per_stable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(per_cur[p]) |-> !per_rst[p]);
  end
endmodule

// File: tb/test_prc_top.sv
module test_prc_top;
  localparam int CLK_PER = 10;
  localparam int NDMA = 3;
  localparam int NPER = 4;
  localparam int AW   = 4;
  localparam int NREG = 5 + NPER;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] core_off, core_on;
  logic [NDMA-1:0] dma_rst;
  logic [NPER-1:0] per_rst;

  int checks = 0, errors = 0;
  logic [31:0] mdl [NREG];

  prc_top #(.N_DMA_CH(NDMA), .N_PERIPH(NPER), .ADDR_W(AW)) i_prc_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .core_off(core_off), .core_on(core_on),
    .dma_rst(dma_rst), .per_rst(per_rst)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [31:0] b_mask(int a);
    if (a == 0) return 32'h17;
    if (a == 2) return 32'hF;
    if (a == 3) return 32'h33;
    if (a == 4) return 32'h3;
    return 32'h1;
  endfunction

  function automatic logic [31:0] b_init(int a);
    if (a == 0) return 32'h17;
    if (a == 2) return 32'hF;
    if (a == 3) return 32'h33;
    if (a == 4) return 32'h3;
    return 32'h1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle, then check what follows the accepting edge
  task automatic op(logic wr, int a, logic [31:0] d);
    logic [1:0] eoff = '0, eon = '0;
    logic edma = 1'b0;
    logic [NPER-1:0] eper = '0;
    logic [31:0] old, nv;
    if (wr && a < NREG) begin
      old = mdl[a];
      nv = d & b_mask(a);
      if (a == 0)
        for (int c = 0; c < 2; c++) begin
          eoff[c] = !old[c] && nv[c];
          eon[c]  = old[c] && !nv[c];
        end
      if (a == 1) edma = old[0] != nv[0];
      if (a >= 5) eper[a-5] = old[0] != nv[0];
      mdl[a] = nv;
    end
    wr_en = wr; addr = AW'(a); wdata = d;
    @(negedge clk);
    chk("R6 core_off", 32'(core_off), 32'(eoff));
    chk("R7 core_on", 32'(core_on), 32'(eon));
    chk("R9 dma_rst", 32'(dma_rst), edma ? 32'((1 << NDMA) - 1) : 32'h0);
    chk("R8 per_rst", 32'(per_rst), 32'(eper));
    if (a < NREG) chk("R3 rdata", rdata, mdl[a]);
    else          chk("R4 rdata", rdata, 32'h0);
    wr_en = 0;
  endtask

  initial begin
    #(CLK_PER * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] sd;
    for (int i = 0; i < NREG; i++) mdl[i] = b_init(i);
    repeat (3) @(negedge clk);
    chk("R1 idle in reset", 32'({core_off, core_on, dma_rst, per_rst}), 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 no action at reset exit", 32'({core_off, core_on, dma_rst, per_rst}), 32'h0);
    // R1 R2: reset values at every mapped address
    for (int a = 0; a < NREG; a++) begin
      addr = AW'(a);
      #1 chk("R1 R2 init value", rdata, b_init(a));
    end
    // directed
    op(1, 0, 32'hFFFF_FFFF);  // R5: value unchanged, R3 bit 3 reserved
    op(1, 0, 32'h0);          // R7 both cores
    op(0, 0, 32'h0);          // R11 strobe gone
    op(1, 0, 32'h1);          // R6 core 0 only
    op(1, 0, 32'h13);         // R6 core 1, R10 bit 4
    op(1, 0, 32'h17);         // R10 bit 2 alone: no action
    op(1, 5, 32'h0);          // R8 falling
    op(1, 5, 32'h0);          // R5 repeat
    op(1, 5, 32'hFFFF_FFFE);  // R10 upper bits ignored
    op(1, 8, 32'h0);          // R8 last peripheral
    op(1, 8, 32'h1);          // R8 rising
    op(1, 1, 32'h0);          // R9 fan-out
    op(0, 1, 32'h0);          // R11
    op(1, 2, 32'h0);          // R10 timer silent
    op(1, 3, 32'hFFFF_FFFF);  // R10 R3 debug mask
    op(1, 4, 32'h0);          // R10 full-power domain
    op(1, 15, 32'hFFFF_FFFF); // R4 unmapped
    op(1, 9, 32'h1);          // R4 first unmapped
    // R2: map intact after unmapped writes
    for (int a = 0; a < NREG; a++) op(0, a, 32'h0);
    // constrained random
    sd = $urandom(32'h5eed);
    for (int n = 0; n < 400; n++) begin
      int a;
      logic [31:0] d;
      a = int'($urandom_range(15, 0));
      d = ($urandom_range(3, 0) == 0) ? $urandom : 32'($urandom_range(3, 0));
      op($urandom_range(3, 0) != 0, a, d);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule